// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order processor for a 32-bit load/store instruction subset: register-to-register arithmetic and logic, add-immediate, word load, word store and branch-on-equal. Each instruction moves through five stages: fetch, decode with register read, execute, memory access and write-back. A register boundary separates every pair of neighbouring stages. Decode generates the control fields, and these travel with the instruction. The register-file write happens only in write-back. The program and the data each sit in their own internal array, so a fetch never contends with a load or store.

No hazard logic exists. There is no forwarding, no interlock and no prediction. Software must place at least two unrelated instructions or nops between a producer and its consumer. Three instructions after a branch-on-equal are discarded when the branch is taken. The program is written into instruction memory through a valid/ready stream while the core is halted. The `run` pin advances the pipeline. A debug port reports each committed register write, and a combinational read port exposes any register.

Back-pressure rules for the program stream: `ld_ready` is high exactly when `run` is low. A word transfers on a clock edge where both `ld_valid` and `ld_ready` are high. While `ld_ready` is low, the word and its index must be held until the transfer happens, or be withdrawn. Data is never taken without `ld_ready`.

Top module: `core_pipe5`

## Requirements
- R1: After reset the fetch address is 0, every inter-stage register holds a bubble, all registers and data words read 0, and `dbg_wb_valid` is low.
- R2: A program word is written at `ld_addr` on an edge with `ld_valid` and `ld_ready` both high. `ld_ready` is low while `run` is high, and an offered word then has no effect.
- R3: While `run` is low, the fetch address, the inter-stage registers, the register file and the data memory all hold their values, and no write-back is reported.
- R4: Register-format instructions use opcode 0 in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11 and funct in 5:0. The funct values are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x27 nor and 0x2A signed set-less-than. The result is written to rd.
- R5: Add-immediate (opcode 0x08) writes rs plus the sign-extended 16-bit immediate in bits 15:0 to rt.
- R6: Load (0x23) and store (0x2B) form the byte address rs + sign-extended immediate in execute. The word index is that address divided by 4, modulo the data depth. A load writes the word to rt, and a store writes rt to memory.
- R7: Register 0 always reads 0, and writes to it are discarded and not reported.
- R8: A value written back is visible to an instruction three slots later, because a register read in the same cycle as the write returns the new value.
- R9: A taken branch-on-equal (opcode 0x04) resolves in the memory stage. It loads the fetch address with pc+4+4·imm and turns the three younger instructions into bubbles.
- R10: A branch-on-equal whose operands differ has no effect, and the following instructions commit.
- R11: With `run` high and no taken branch, the fetch address rises by 4 every cycle, and back-to-back instructions commit on consecutive cycles.
- R12: `dbg_wb_valid` pulses for each committed write to a nonzero register, with the register and value. The first instruction commits on the fourth edge after `run` rises.
- R13: A consumer placed one or two slots after its producer reads the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Pipeline advances when high |
| ld_valid | input | 1 | Program word offered |
| ld_ready | output | 1 | Program word accepted (core halted) |
| ld_addr | input | IA_W | Program word index |
| ld_data | input | 32 | Program word |
| dbg_rd_addr | input | 5 | Register to inspect |
| dbg_rd_data | output | 32 | Contents of inspected register |
| dbg_wb_valid | output | 1 | A register write commits this cycle |
| dbg_wb_reg | output | 5 | Register being written |
| dbg_wb_data | output | 32 | Value being written |

## Verification
The checker watches several properties on every cycle. It confirms that the fetch address either steps by 4, jumps to the branch target after a taken branch, or stays frozen while halted. It confirms that a taken branch empties the three younger stages on the next edge. It also confirms that register 0 reads zero, that reported write-backs never name register 0, and that the loader is refused while running. Results that depend on the program can only be shown by the bench's scenarios. These include the arithmetic outcomes, the load and store round trip, the stale reads at distance one and two against the fresh read at distance three, and the discarded shadow of a taken branch. The freeze in mid-flight and a load offered while running are also covered only by the scenarios.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;
  localparam logic [5:0] OP_BEQ  = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AOP_ADD  = 2'b00,
    AOP_SUB  = 2'b01,
    AOP_FUNC = 2'b10
  } aop_e;

  typedef enum logic [3:0] {
    AF_AND = 4'b0000,
    AF_OR  = 4'b0001,
    AF_ADD = 4'b0010,
    AF_SUB = 4'b0110,
    AF_SLT = 4'b0111,
    AF_NOR = 4'b1100
  } afn_e;

  typedef struct packed {
    logic reg_write;
    logic mem_write;
    logic branch;
    logic alu_src;
    logic mem_to_reg;
    logic reg_dst;
    aop_e alu_op;
  } ctrl_t;

  typedef struct packed {
    logic            valid;
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] instr;
  } ifid_t;

  typedef struct packed {
    logic            valid;
    logic            reg_write;
    logic            mem_write;
    logic            branch;
    logic            mem_to_reg;
    logic            alu_src;
    aop_e            alu_op;
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] imm;
    logic [4:0]      dest;
  } idex_t;

  typedef struct packed {
    logic            valid;
    logic            reg_write;
    logic            mem_write;
    logic            branch;
    logic            mem_to_reg;
    logic [XLEN-1:0] y;
    logic            zero;
    logic [XLEN-1:0] sdata;
    logic [XLEN-1:0] tgt;
    logic [4:0]      dest;
  } exmem_t;

  typedef struct packed {
    logic            valid;
    logic            reg_write;
    logic [4:0]      dest;
    logic [XLEN-1:0] val;
  } memwb_t;
endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = AOP_ADD;
    unique case (opcode)
      OP_REG: begin
        ctrl.reg_write = 1'b1;
        ctrl.reg_dst   = 1'b1;
        ctrl.alu_op    = AOP_FUNC;
      end
      OP_ADDI: begin
        ctrl.reg_write = 1'b1;
        ctrl.alu_src   = 1'b1;
      end
      OP_LOAD: begin
        ctrl.reg_write  = 1'b1;
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_STOR: begin
        ctrl.mem_write = 1'b1;
        ctrl.alu_src   = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = AOP_SUB;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
(
  input  aop_e            alu_op,
  input  logic [5:0]      funct,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  afn_e fn;

  always_comb begin
    fn = AF_ADD;
    case (alu_op)
      AOP_SUB:  fn = AF_SUB;
      AOP_FUNC: begin
        case (funct)
          FN_SUB:  fn = AF_SUB;
          FN_AND:  fn = AF_AND;
          FN_OR:   fn = AF_OR;
          FN_NOR:  fn = AF_NOR;
          FN_SLT:  fn = AF_SLT;
          default: fn = AF_ADD;
        endcase
      end
      default: fn = AF_ADD;
    endcase
  end

  always_comb begin
    case (fn)
      AF_AND:  y = a & b;
      AF_OR:   y = a | b;
      AF_SUB:  y = a - b;
      AF_SLT:  y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      AF_NOR:  y = ~(a | b);
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/core_regfile.sv
module core_regfile
  import core_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] ra1,
  input  logic [RA_W-1:0] ra2,
  input  logic [RA_W-1:0] ra3,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  output logic [XLEN-1:0] rd3,
  input  logic            we,
  input  logic [RA_W-1:0] wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] regs [NREG];
  logic            wr_ok;

  assign wr_ok = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_ok) begin
      regs[wa] <= wd;
    end
  end

  // write-through: a same-cycle read sees the value being written
  always_comb begin
    rd1 = (wr_ok && wa == ra1) ? wd : regs[ra1];
    rd2 = (wr_ok && wa == ra2) ? wd : regs[ra2];
    if (ra1 == '0) rd1 = '0;
    if (ra2 == '0) rd2 = '0;
    rd3 = (ra3 == '0) ? '0 : regs[ra3];
  end
endmodule

// File: rtl/core_pipe5.sv
module core_pipe5
  import core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA_W = $clog2(IMEM_WORDS),
  localparam int DA_W = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic [IA_W-1:0] ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [4:0]      dbg_rd_addr,
  output logic [XLEN-1:0] dbg_rd_data,
  output logic            dbg_wb_valid,
  output logic [4:0]      dbg_wb_reg,
  output logic [XLEN-1:0] dbg_wb_data
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc_q;
  ifid_t           ifid_q;
  idex_t           idex_q;
  exmem_t          exmem_q;
  memwb_t          memwb_q;

  // ---------------- program loader ----------------
  assign ld_ready = !run;

  always_ff @(posedge clk) begin
    if (ld_valid && ld_ready) imem[ld_addr] <= ld_data;
  end

  // ---------------- fetch ----------------
  logic [XLEN-1:0] if_instr;
  logic [XLEN-1:0] if_pc4;
  logic            mem_taken;

  assign if_instr = imem[pc_q[IA_W+1:2]];
  assign if_pc4   = pc_q + 32'd4;

  // ---------------- decode ----------------
  ctrl_t           dec_ctrl;
  ctrl_t           id_ctrl;
  logic [XLEN-1:0] id_a, id_b, id_imm;
  logic [4:0]      id_rs, id_rt, id_rd, id_dest;
  logic            wb_we;

  assign id_rs  = ifid_q.instr[25:21];
  assign id_rt  = ifid_q.instr[20:16];
  assign id_rd  = ifid_q.instr[15:11];
  assign id_imm = {{(XLEN-16){ifid_q.instr[15]}}, ifid_q.instr[15:0]};

  core_decode u_dec (
    .opcode (ifid_q.instr[31:26]),
    .ctrl   (dec_ctrl)
  );

  always_comb begin
    id_ctrl = dec_ctrl;
    if (!ifid_q.valid) id_ctrl = '0;
  end

  assign id_dest = id_ctrl.reg_dst ? id_rd : id_rt;
  assign wb_we   = run && memwb_q.valid && memwb_q.reg_write;

  core_regfile #(.NREG(32)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (id_rs),
    .ra2   (id_rt),
    .ra3   (dbg_rd_addr),
    .rd1   (id_a),
    .rd2   (id_b),
    .rd3   (dbg_rd_data),
    .we    (wb_we),
    .wa    (memwb_q.dest),
    .wd    (memwb_q.val)
  );

  // ---------------- execute ----------------
  logic [XLEN-1:0] ex_b, ex_y, ex_tgt;
  logic            ex_zero;

  assign ex_b   = idex_q.alu_src ? idex_q.imm : idex_q.b;
  assign ex_tgt = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};

  core_alu u_alu (
    .alu_op (idex_q.alu_op),
    .funct  (idex_q.imm[5:0]),
    .a      (idex_q.a),
    .b      (ex_b),
    .y      (ex_y),
    .zero   (ex_zero)
  );

  // ---------------- memory ----------------
  logic [DA_W-1:0] mem_idx;
  logic [XLEN-1:0] mem_rdata;

  assign mem_idx   = exmem_q.y[DA_W+1:2];
  assign mem_rdata = dmem[mem_idx];
  assign mem_taken = exmem_q.valid && exmem_q.branch && exmem_q.zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
    end else if (run && exmem_q.valid && exmem_q.mem_write) begin
      dmem[mem_idx] <= exmem_q.sdata;
    end
  end

  // ---------------- stage registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ifid_q  <= '0;
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else if (run) begin
      pc_q <= mem_taken ? exmem_q.tgt : if_pc4;

      if (mem_taken) begin
        ifid_q  <= '0;
        idex_q  <= '0;
        exmem_q <= '0;
      end else begin
        ifid_q.valid <= 1'b1;
        ifid_q.pc4   <= if_pc4;
        ifid_q.instr <= if_instr;

        idex_q.valid      <= ifid_q.valid;
        idex_q.reg_write  <= id_ctrl.reg_write;
        idex_q.mem_write  <= id_ctrl.mem_write;
        idex_q.branch     <= id_ctrl.branch;
        idex_q.mem_to_reg <= id_ctrl.mem_to_reg;
        idex_q.alu_src    <= id_ctrl.alu_src;
        idex_q.alu_op     <= id_ctrl.alu_op;
        idex_q.pc4        <= ifid_q.pc4;
        idex_q.a          <= id_a;
        idex_q.b          <= id_b;
        idex_q.imm        <= id_imm;
        idex_q.dest       <= id_dest;

        exmem_q.valid      <= idex_q.valid;
        exmem_q.reg_write  <= idex_q.reg_write;
        exmem_q.mem_write  <= idex_q.mem_write;
        exmem_q.branch     <= idex_q.branch;
        exmem_q.mem_to_reg <= idex_q.mem_to_reg;
        exmem_q.y          <= ex_y;
        exmem_q.zero       <= ex_zero;
        exmem_q.sdata      <= idex_q.b;
        exmem_q.tgt        <= ex_tgt;
        exmem_q.dest       <= idex_q.dest;
      end

      memwb_q.valid     <= exmem_q.valid;
      memwb_q.reg_write <= exmem_q.reg_write;
      memwb_q.dest      <= exmem_q.dest;
      memwb_q.val       <= exmem_q.mem_to_reg ? mem_rdata : exmem_q.y;
    end
  end

  // ---------------- debug write-back ----------------
  assign dbg_wb_valid = wb_we && (memwb_q.dest != 5'd0);
  assign dbg_wb_reg   = memwb_q.dest;
  assign dbg_wb_data  = memwb_q.val;
endmodule

// File: rtl/core_pipe5_chk.sv
module core_pipe5_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        ld_valid,
  input logic        ld_ready,
  input logic [31:0] pc,
  input logic        taken,
  input logic [31:0] tgt,
  input logic        ifid_v,
  input logic        idex_v,
  input logic        exmem_v,
  input logic [4:0]  dbg_rd_addr,
  input logic [31:0] dbg_rd_data,
  input logic        dbg_wb_valid,
  input logic [4:0]  dbg_wb_reg
);
  AST_LOAD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ld_valid) |-> !ld_ready); // R2

  AST_FREEZE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc)); // R3

  AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !taken) |=> pc == $past(pc) + 32'd4); // R11

  AST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && taken) |=> pc == $past(tgt)); // R9

  AST_SHADOW_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && taken) |=> (!ifid_v && !idex_v && !exmem_v)); // R9

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rd_addr == 5'd0) |-> dbg_rd_data == 32'd0); // R7

  AST_WB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wb_valid |-> (dbg_wb_reg != 5'd0 && run)); // R12
endmodule

bind core_pipe5 core_pipe5_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run          (run),
  .ld_valid     (ld_valid),
  .ld_ready     (ld_ready),
  .pc           (pc_q),
  .taken        (mem_taken),
  .tgt          (exmem_q.tgt),
  .ifid_v       (ifid_q.valid),
  .idex_v       (idex_q.valid),
  .exmem_v      (exmem_q.valid),
  .dbg_rd_addr  (dbg_rd_addr),
  .dbg_rd_data  (dbg_rd_data),
  .dbg_wb_valid (dbg_wb_valid),
  .dbg_wb_reg   (dbg_wb_reg)
);

// File: tb/core_pipe5_test.sv
module core_pipe5_test;
  localparam int IA_W = 6;
  localparam int NEXP = 23;

  // {register, expected value, requirement number}
  localparam logic [40:0] EXP_TAB [NEXP] = '{
    {5'd1,  32'h0000_0005, 4'd5},   // R5
    {5'd2,  32'hFFFF_FFFD, 4'd5},   // R5
    {5'd3,  32'h0000_000C, 4'd5},   // R5
    {5'd4,  32'h0000_0002, 4'd4},   // R4 add
    {5'd5,  32'h0000_0008, 4'd4},   // R4 sub
    {5'd6,  32'h0000_0004, 4'd4},   // R4 and
    {5'd7,  32'h0000_000D, 4'd4},   // R4 or
    {5'd8,  32'h0000_0001, 4'd4},   // R4 slt true
    {5'd9,  32'h0000_0000, 4'd4},   // R4 slt false
    {5'd10, 32'hFFFF_FFF2, 4'd4},   // R4 nor
    {5'd0,  32'h0000_0000, 4'd7},   // R7
    {5'd11, 32'h0000_0002, 4'd6},   // R6
    {5'd12, 32'h0000_000C, 4'd6},   // R6
    {5'd14, 32'h0000_0064, 4'd5},   // R5
    {5'd15, 32'h0000_0000, 4'd13},  // R13
    {5'd16, 32'h0000_0000, 4'd13},  // R13
    {5'd17, 32'h0000_0064, 4'd8},   // R8
    {5'd18, 32'h0000_0000, 4'd9},   // R9
    {5'd19, 32'h0000_0000, 4'd9},   // R9
    {5'd20, 32'h0000_0000, 4'd9},   // R9
    {5'd21, 32'h0000_0000, 4'd9},   // R9
    {5'd22, 32'h0000_004D, 4'd10},  // R10
    {5'd23, 32'hFFFF_8000, 4'd5}    // R5
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            run = 1'b0;
  logic            ld_valid = 1'b0;
  logic            ld_ready;
  logic [IA_W-1:0] ld_addr = '0;
  logic [31:0]     ld_data = '0;
  logic [4:0]      dbg_rd_addr = '0;
  logic [31:0]     dbg_rd_data;
  logic            dbg_wb_valid;
  logic [4:0]      dbg_wb_reg;
  logic [31:0]     dbg_wb_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [31:0] prog [64];

  int          wb_n = 0;
  logic [4:0]  wb_reg [64];
  logic [31:0] wb_val [64];
  int          wb_cyc [64];

  core_pipe5 uut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_rd_addr(dbg_rd_addr), .dbg_rd_data(dbg_rd_data),
    .dbg_wb_valid(dbg_wb_valid), .dbg_wb_reg(dbg_wb_reg), .dbg_wb_data(dbg_wb_data)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && dbg_wb_valid && wb_n < 64) begin
      wb_reg[wb_n] = dbg_wb_reg;
      wb_val[wb_n] = dbg_wb_data;
      wb_cyc[wb_n] = cyc;
      wb_n++;
    end
  end

  function automatic string rname(input int n);
    case (n)
      4: return "R4";  5: return "R5";  6: return "R6";  7: return "R7";
      8: return "R8";  9: return "R9";  10: return "R10"; 13: return "R13";
      default: return "R?";
    endcase
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    logic [4:0] s, t, d;
    s = rs[4:0]; t = rt[4:0]; d = rd[4:0];
    return {6'h00, s, t, d, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    logic [4:0] s, t;
    logic [15:0] im;
    s = rs[4:0]; t = rt[4:0]; im = imm[15:0];
    return {op, s, t, im};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input int r, output logic [31:0] v);
    @(negedge clk);
    dbg_rd_addr = r[4:0];
    #1;
    v = dbg_rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    run = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_for(input int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] snap [5];
    int c0, n_before;

    for (int i = 0; i < 64; i++) prog[i] = 32'd0;
    prog[0]  = enc_i(6'h08, 0, 1, 5);
    prog[1]  = enc_i(6'h08, 0, 2, -3);
    prog[2]  = enc_i(6'h08, 0, 3, 12);
    prog[5]  = enc_r(1, 2, 4, 6'h20);
    prog[6]  = enc_r(1, 2, 5, 6'h22);
    prog[7]  = enc_r(1, 3, 6, 6'h24);
    prog[8]  = enc_r(1, 3, 7, 6'h25);
    prog[9]  = enc_r(2, 1, 8, 6'h2A);
    prog[10] = enc_r(1, 2, 9, 6'h2A);
    prog[11] = enc_r(1, 3, 10, 6'h27);
    prog[12] = enc_i(6'h2B, 0, 3, 8);
    prog[13] = enc_i(6'h2B, 3, 4, 16);
    prog[14] = enc_i(6'h08, 0, 0, 7);
    prog[16] = enc_i(6'h23, 0, 11, 28);
    prog[17] = enc_i(6'h23, 3, 12, -4);
    prog[18] = enc_i(6'h08, 0, 14, 100);
    prog[19] = enc_r(14, 0, 15, 6'h20);
    prog[20] = enc_r(14, 0, 16, 6'h20);
    prog[21] = enc_r(14, 0, 17, 6'h20);
    prog[22] = enc_i(6'h04, 1, 1, 4);
    prog[23] = enc_i(6'h08, 0, 18, 1);
    prog[24] = enc_i(6'h08, 0, 19, 1);
    prog[25] = enc_i(6'h08, 0, 20, 1);
    prog[26] = enc_i(6'h08, 0, 21, 1);
    prog[27] = enc_i(6'h04, 1, 2, 1);
    prog[28] = enc_i(6'h08, 0, 22, 77);
    prog[29] = enc_i(6'h08, 0, 23, -32768);
    prog[30] = enc_i(6'h04, 0, 0, -1);

    // reset state (R1)
    do_reset();
    #1;
    chk("R1 ld_ready", {31'd0, ld_ready}, 32'd1);
    chk("R1 wb_valid", {31'd0, dbg_wb_valid}, 32'd0);
    rd_reg(5, v);  chk("R1 reg5", v, 32'd0);
    rd_reg(31, v); chk("R1 reg31", v, 32'd0);

    // program load through the stream port (R2)
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_addr  = i[IA_W-1:0];
      ld_data  = prog[i];
      #1;
      chk("R2 ready while halted", {31'd0, ld_ready}, 32'd1);
    end
    @(negedge clk);
    ld_valid = 1'b0;

    // main run
    wb_n = 0;
    @(negedge clk);
    c0 = cyc;
    run = 1'b1;
    repeat (120) @(negedge clk);
    run = 1'b0;

    for (int i = 0; i < NEXP; i++) begin
      rd_reg(int'(EXP_TAB[i][40:36]), v);
      chk(rname(int'(EXP_TAB[i][3:0])), v, EXP_TAB[i][35:4]);
    end

    // write-back reporting and throughput (R11, R12)
    chk("R12 commit count", wb_n, 32'd18);
    chk("R12 first reg", {27'd0, wb_reg[0]}, 32'd1);
    chk("R12 first value", wb_val[0], 32'd5);
    chk("R12 first commit cycle", wb_cyc[0], c0 + 4);
    chk("R11 second back-to-back", wb_cyc[1], wb_cyc[0] + 1);
    chk("R11 third back-to-back", wb_cyc[2], wb_cyc[1] + 1);
    chk("R11 third reg", {27'd0, wb_reg[2]}, 32'd3);
    chk("R11 second value", wb_val[1], 32'hFFFF_FFFD);

    // offer a word while running: refused and ignored (R2)
    @(negedge clk);
    run = 1'b1;
    ld_valid = 1'b1;
    ld_addr = '0;
    ld_data = enc_i(6'h08, 0, 1, 99);
    #1;
    chk("R2 ready low while running", {31'd0, ld_ready}, 32'd0);
    @(negedge clk);
    ld_valid = 1'b0;
    run = 1'b0;

    // freeze mid-flight (R3)
    do_reset();
    wb_n = 0;
    run_for(9);
    n_before = wb_n;
    for (int r = 1; r <= 4; r++) begin
      rd_reg(r, v);
      snap[r] = v;
    end
    repeat (15) @(negedge clk);
    chk("R3 no commit while halted", wb_n, n_before);
    for (int r = 1; r <= 4; r++) begin
      rd_reg(r, v);
      chk("R3 register held", v, snap[r]);
    end

    // resume and finish: program unchanged, results intact (R2, R3)
    run_for(120);
    rd_reg(1, v);  chk("R2 word offered while running ignored", v, 32'd5);
    rd_reg(4, v);  chk("R3 resume add", v, 32'd2);
    rd_reg(12, v); chk("R3 resume load", v, 32'd12);
    rd_reg(22, v); chk("R10 resume", v, 32'd77);
    rd_reg(19, v); chk("R9 resume shadow", v, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule